// File: doc/BRIEF.md
# Sixteen-Bit Timer with Selectable Wrap Point

This block is an up-counting 16-bit timer whose wrap point (TOP) is picked by a three-bit mode input. The wrap point can be one of three fixed constants (0x00FF, 0x01FF, 0x03FF), the full count range, an active compare-A value or a capture value. The counter advances only on clock cycles where the `tick` enable is high, so an external prescaler sets its rate.

When compare A provides the wrap point, a written compare value first lands in a holding register. It is copied into the active compare value only when the counter wraps, so a period that is already running is never cut short or stretched. In every other mode a compare write takes effect on the next cycle. Selecting the capture value as the wrap point leaves compare A free to serve as an ordinary match channel. The block has two sticky flags: a compare-A match flag and an overflow flag. Each is cleared by writing a one. A one-cycle strobe marks every wrap at TOP.

Top module: `tmr16_topsel`

## Requirements
- R1: After reset, `count` is 0x0000 and `cmpa_flag`, `ovf_flag` and `top_strobe` are all low. The active compare-A value and the capture value both reset to 0x0000.
- R2: While `tick` is low, `count` keeps its value.
- R3: In modes 0, 1 and 2, TOP is 0x00FF, 0x01FF and 0x03FF respectively. On a tick with `count` equal to TOP, `count` becomes 0x0000 on the next cycle and `top_strobe` is high for exactly that one cycle.
- R4: In mode 3, TOP is the active compare-A value. A write to compare A updates only the holding register. The holding register is copied into the active value on the cycle the counter wraps to 0x0000.
- R5: In mode 4, TOP is the capture value. A capture write takes effect on the next cycle. Outside mode 3, a compare-A write also reaches the active value on the next cycle.
- R6: In modes 5, 6 and 7, TOP is 0xFFFF.
- R7: If TOP lies below the current count, the counter keeps counting up to 0xFFFF and then wraps to 0x0000.
- R8: On a tick with `count` at 0xFFFF, `ovf_flag` is set on the next cycle. It stays set until a cycle with `flag_clr[1]` high.
- R9: On a tick with `count` equal to the active compare-A value, `cmpa_flag` is set on the next cycle. It stays set until a cycle with `flag_clr[0]` high.
- R10: When a flag's set event and its clear bit occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for this cycle |
| mode | input | 3 | Wrap-point select (see R3 to R6) |
| cmpa_we | input | 1 | Compare-A write strobe |
| cmpa_wdata | input | 16 | Compare-A write value |
| capr_we | input | 1 | Capture-value write strobe |
| capr_wdata | input | 16 | Capture-value write value |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 clears the match flag, bit 1 clears the overflow flag |
| count | output | 16 | Current count |
| cmpa_flag | output | 1 | Sticky compare-A match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| top_strobe | output | 1 | One-cycle pulse after a wrap at TOP |

## Verification
Every result is registered. The count, the strobe and both flags therefore show the effect of a tick one clock edge after that tick. A compare or capture write needs one edge before it can steer the wrap point. The bench drives all inputs on the falling edge and samples on the next falling edge, so each check sees exactly the state after the edges it counted. Buffered compare-A behaviour is observed through the count at which the wrap actually happens.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int TW = 16;
  localparam logic [TW-1:0] MAXV  = {TW{1'b1}};
  localparam logic [TW-1:0] FIX8  = TW'((1 << 8) - 1);
  localparam logic [TW-1:0] FIX9  = TW'((1 << 9) - 1);
  localparam logic [TW-1:0] FIX10 = TW'((1 << 10) - 1);

  localparam logic [2:0] MD_FIX8 = 3'd0;
  localparam logic [2:0] MD_FIX9 = 3'd1;
  localparam logic [2:0] MD_FIX10 = 3'd2;
  localparam logic [2:0] MD_CMPA = 3'd3;
  localparam logic [2:0] MD_CAPR = 3'd4;

  // Wrap point for a given mode
  function automatic logic [TW-1:0] top_of(input logic [2:0] md,
                                           input logic [TW-1:0] cmpa,
                                           input logic [TW-1:0] capr);
    case (md)
      MD_FIX8:  top_of = FIX8;
      MD_FIX9:  top_of = FIX9;
      MD_FIX10: top_of = FIX10;
      MD_CMPA:  top_of = cmpa;
      MD_CAPR:  top_of = capr;
      default:  top_of = MAXV;
    endcase
  endfunction

  // Next count on a tick: wrap at TOP or at MAX, else increment
  function automatic logic [TW-1:0] next_count(input logic [TW-1:0] cur,
                                               input logic [TW-1:0] top);
    if (cur == top || cur == MAXV) next_count = '0;
    else next_count = cur + TW'(1);
  endfunction
endpackage

// File: rtl/tmr16_topsrc.sv
module tmr16_topsrc
  import tmr16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          cmpa_we,
  input  logic [TW-1:0] cmpa_wdata,
  input  logic          capr_we,
  input  logic [TW-1:0] capr_wdata,
  input  logic          wrap_evt,
  output logic [TW-1:0] top_val,
  output logic [TW-1:0] cmpa_act
);
  logic [TW-1:0] cmpa_hold, hold_nxt, capr_q;
  logic          buffered;

  assign buffered = (mode == MD_CMPA);
  assign hold_nxt = cmpa_we ? cmpa_wdata : cmpa_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpa_hold <= '0;
      cmpa_act  <= '0;
      capr_q    <= '0;
    end else begin
      cmpa_hold <= hold_nxt;
      if (!buffered) cmpa_act <= hold_nxt;
      else if (wrap_evt) cmpa_act <= cmpa_hold;
      if (capr_we) capr_q <= capr_wdata;
    end
  end

  assign top_val = top_of(mode, cmpa_act, capr_q);

  // R4: in buffered mode the active value only moves at a wrap
  p_buffered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !wrap_evt) |=> $stable(cmpa_act));
  // R5: capture write is visible next cycle
  p_capr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (capr_we && mode == MD_CAPR) |=> (mode != MD_CAPR || top_val == $past(capr_wdata)));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [TW-1:0] top_val,
  input  logic [TW-1:0] cmpa_act,
  output logic [TW-1:0] count,
  output logic          top_strobe,
  output logic          wrap_evt,
  output logic          ovf_evt,
  output logic          match_evt
);
  logic at_top;

  assign at_top    = (count == top_val);
  assign ovf_evt   = tick && (count == MAXV);
  assign wrap_evt  = tick && (at_top || count == MAXV);
  assign match_evt = tick && (count == cmpa_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      top_strobe <= 1'b0;
    end else begin
      top_strobe <= tick && at_top;
      if (tick) count <= next_count(count, top_val);
    end
  end

  // R2: no tick, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R3: a tick at TOP returns to bottom with a strobe
  p_wrap_to_bottom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_top) |=> (count == '0 && top_strobe));
  // R7: above TOP but below MAX the counter still increments
  p_above_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count > top_val && count != MAXV) |=> (count == $past(count) + TW'(1)));
  // R7: from MAX the counter goes to zero
  p_max_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count == '0));
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_evt,
  input  logic       match_evt,
  input  logic [1:0] flag_clr,
  output logic       cmpa_flag,
  output logic       ovf_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpa_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (match_evt) cmpa_flag <= 1'b1;
      else if (flag_clr[0]) cmpa_flag <= 1'b0;
      if (ovf_evt) ovf_flag <= 1'b1;
      else if (flag_clr[1]) ovf_flag <= 1'b0;
    end
  end

  // R8 / R10: overflow event always leaves the flag set
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr[1]) |=> ovf_flag);
  // R9 / R10: match event always leaves the flag set
  p_match_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmpa_flag);
  p_match_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_flag && !flag_clr[0]) |=> cmpa_flag);
endmodule

// File: rtl/tmr16_topsel.sv
module tmr16_topsel
  import tmr16_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [2:0]    mode,
  input  logic          cmpa_we,
  input  logic [TW-1:0] cmpa_wdata,
  input  logic          capr_we,
  input  logic [TW-1:0] capr_wdata,
  input  logic [1:0]    flag_clr,
  output logic [TW-1:0] count,
  output logic          cmpa_flag,
  output logic          ovf_flag,
  output logic          top_strobe
);
  logic [TW-1:0] top_val, cmpa_act;
  logic          wrap_evt, ovf_evt, match_evt;

  tmr16_topsrc u_src (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata),
    .capr_we(capr_we), .capr_wdata(capr_wdata),
    .wrap_evt(wrap_evt), .top_val(top_val), .cmpa_act(cmpa_act)
  );

  tmr16_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .top_val(top_val), .cmpa_act(cmpa_act),
    .count(count), .top_strobe(top_strobe),
    .wrap_evt(wrap_evt), .ovf_evt(ovf_evt), .match_evt(match_evt)
  );

  tmr16_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .flag_clr(flag_clr), .cmpa_flag(cmpa_flag), .ovf_flag(ovf_flag)
  );

  // R1: reset state as seen at the ports
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && !cmpa_flag && !ovf_flag && !top_strobe));
endmodule

// File: tb/tmr16_topsel_test.sv
module tmr16_topsel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        cmpa_we = 1'b0;
  logic [15:0] cmpa_wdata = '0;
  logic        capr_we = 1'b0;
  logic [15:0] capr_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [15:0] count;
  logic        cmpa_flag, ovf_flag, top_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr16_topsel uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata),
    .capr_we(capr_we), .capr_wdata(capr_wdata),
    .flag_clr(flag_clr), .count(count), .cmpa_flag(cmpa_flag),
    .ovf_flag(ovf_flag), .top_strobe(top_strobe)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic [15:0] n;
    logic [15:0] cnt;
    logic        stb;
  } vec_t;

  // R3 / R6 / R5: after reset, n ticks in mode md
  localparam vec_t VT [0:10] = '{
    '{3'd0, 16'd255,  16'd255, 1'b0},
    '{3'd0, 16'd256,  16'd0,   1'b1},
    '{3'd0, 16'd300,  16'd44,  1'b0},
    '{3'd1, 16'd511,  16'd511, 1'b0},
    '{3'd1, 16'd512,  16'd0,   1'b1},
    '{3'd2, 16'd1024, 16'd0,   1'b1},
    '{3'd2, 16'd1030, 16'd6,   1'b0},
    '{3'd5, 16'd1030, 16'd1030, 1'b0},
    '{3'd6, 16'd1024, 16'd1024, 1'b0},
    '{3'd7, 16'd600,  16'd600, 1'b0},
    '{3'd4, 16'd5,    16'd0,   1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_cmpa(input logic [15:0] v);
    cmpa_we = 1'b1; cmpa_wdata = v;
    @(negedge clk);
    cmpa_we = 1'b0;
  endtask

  task automatic wr_capr(input logic [15:0] v);
    capr_we = 1'b1; capr_wdata = v;
    @(negedge clk);
    capr_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 count", count, 16'h0);
    chk("R1 flags", {14'd0, cmpa_flag, ovf_flag}, 16'h0);
    chk("R1 strobe", {15'd0, top_strobe}, 16'h0);

    foreach (VT[i]) begin
      do_reset();
      mode = VT[i].md;
      ticks(int'(VT[i].n));
      chk("R3/R5/R6 vec count", count, VT[i].cnt);
      chk("R3/R5/R6 vec strobe", {15'd0, top_strobe}, {15'd0, VT[i].stb});
    end

    // R2: hold without tick
    do_reset(); mode = 3'd6;
    ticks(7);
    repeat (5) @(negedge clk);
    chk("R2 hold", count, 16'd7);

    // R4: buffered compare A as TOP
    do_reset(); mode = 3'd3;
    wr_cmpa(16'd10);
    ticks(1);                      // wraps at TOP 0, loads 10
    chk("R4 first wrap", count, 16'd0);
    ticks(2);
    wr_cmpa(16'd3);                // buffered, not yet active
    ticks(8);
    chk("R4 old TOP kept", count, 16'd10);
    ticks(1);
    chk("R4 wrap at old TOP", count, 16'd0);
    chk("R4 strobe", {15'd0, top_strobe}, 16'd1);
    ticks(3);
    chk("R4 new TOP reached", count, 16'd3);
    ticks(1);
    chk("R4 new TOP wrap", count, 16'd0);

    // R5: capture as TOP, immediate write
    do_reset(); mode = 3'd4;
    wr_capr(16'd20);
    ticks(15);
    wr_capr(16'd16);
    ticks(1);
    chk("R5 before new TOP", count, 16'd16);
    ticks(1);
    chk("R5 wrap at new capture", count, 16'd0);

    // R9 / R10: match flag, immediate compare write outside mode 3
    do_reset(); mode = 3'd6;
    wr_cmpa(16'd20);
    ticks(20);
    chk("R9 flag not yet", {15'd0, cmpa_flag}, 16'd0);
    ticks(1);
    chk("R9 flag set", {15'd0, cmpa_flag}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", {15'd0, cmpa_flag}, 16'd1);
    flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00;
    chk("R9 flag cleared", {15'd0, cmpa_flag}, 16'd0);
    wr_cmpa(16'd25);
    ticks(4);
    chk("R10 at match count", count, 16'd25);
    flag_clr = 2'b01; tick = 1'b1;
    @(negedge clk);
    flag_clr = 2'b00; tick = 1'b0;
    chk("R10 set wins", {15'd0, cmpa_flag}, 16'd1);

    // R7 / R8: TOP dropped below count, run to MAX
    do_reset(); mode = 3'd6;
    ticks(16'h200);
    mode = 3'd0;
    ticks(16'hFFFF - 16'h200);
    chk("R7 reached max", count, 16'hFFFF);
    chk("R8 no ovf yet", {15'd0, ovf_flag}, 16'd0);
    ticks(1);
    chk("R7 wrap at max", count, 16'h0);
    chk("R8 ovf set", {15'd0, ovf_flag}, 16'd1);
    chk("R7 no TOP strobe", {15'd0, top_strobe}, 16'd0);
    flag_clr = 2'b10; @(negedge clk); flag_clr = 2'b00;
    chk("R8 ovf cleared", {15'd0, ovf_flag}, 16'd0);
    ticks(256);
    chk("R3 fixed TOP resumes", count, 16'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule